// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It pulls 8-bit words from a first-word-fall-through transmit queue and shifts them out most significant bit first. Each word's receive data is shifted in on the same clock edges, and every finished exchange pushes one byte into a receive queue. The serial clock is made from the block clock by a power-of-two divider. Four slave-select lines are driven either as a one-hot active-low set or as a raw binary number for an external decoder. The queues themselves and the bus register decode sit outside this block.

A 17-bit control word configures the block. Its fields are master enable, clock polarity and phase, a 3-bit divider code, decoded-select mode, a 4-bit select field, manual select, manual-start mode and a manual-start trigger. A separate enable input gates all activity. The clock polarity, clock phase and divider code are captured only when that enable rises. Rewriting them while the engine runs therefore cannot disturb the serial clock. An active-low mode-fault input stops the engine. It aborts the byte in flight and raises a single-cycle event.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, ss_n is 4'b1111, sclk is low, and tx_pop, rx_push and fault_evt are all low. The latched clock settings reset to polarity 0, phase 0 and divider code 1.
- R2: Each word is 8 bits, shifted MSB first on mosi. Polarity is ctrl bit 1 and phase is ctrl bit 2. With phase 0, both sides sample on the leading (first) sclk edge of each bit. With phase 1, both sides sample on the trailing edge. Exactly one rx_push, carrying the byte sampled from miso, follows each tx_pop. This holds in all four clock modes.
- R3: Divider code N sits in ctrl bits 5:3. One sclk period lasts 2^(N+1) clock cycles. Code 0 acts as code 1, giving a minimum of divide-by-4, and code 7 divides by 256.
- R4: Polarity, phase and divider code are sampled only on a rising edge of eng_en. Changing them while enabled leaves the idle sclk level and the sclk period unchanged until enable is toggled.
- R5: With ctrl bit 9 clear, the select field in ctrl bits 13:10 is one-hot active-low, so clearing bit k selects slave k. If several bits are clear, only the lowest-numbered of them is driven low. All ones selects nothing.
- R6: With ctrl bit 9 set, the select field is driven on ss_n unchanged, as a binary slave number.
- R7: With ctrl bit 14 clear, the select lines are asserted only while a transfer is in progress. They stay asserted across back-to-back words and return to all ones once the queue runs dry.
- R8: With ctrl bit 14 set, the select field is driven whenever the engine is enabled, transfer or not. It returns to all ones when the engine is disabled.
- R9: With ctrl bit 15 set, no word starts until ctrl bit 16 rises. Each such rising edge then drains the transmit queue until it is empty. Data queued afterwards waits for the next rising edge.
- R10: Words start only while eng_en has risen and stayed high and ctrl bit 0 is set. With bit 15 clear, a word starts whenever these hold and the queue is not empty.
- R11: A low fault_n while the engine is active gives exactly one cycle of fault_evt. The byte in flight is aborted with no rx_push, and sclk returns to its idle level. The engine stays stopped until eng_en rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 17 | Control word (field positions in R2 to R10) |
| eng_en | input | 1 | Engine enable; its rising edge captures clock settings |
| tx_empty | input | 1 | Transmit queue has no data |
| tx_byte | input | WORD_W | Head word of the transmit queue |
| tx_pop | output | 1 | Consume the head word this cycle |
| rx_byte | output | WORD_W | Received word |
| rx_push | output | 1 | rx_byte is valid for one cycle |
| fault_n | input | 1 | Active-low mode-fault input |
| fault_evt | output | 1 | One-cycle mode-fault event |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Slave-select lines |

## Verification
The bench uses the default WORD_W of 8, the word length the control format assumes, so every edge-count and byte check reflects a real exchange. It drives divider codes 0 through 3 and 7 across the four clock modes. That covers the clamped minimum divider, the largest half-period counter value and back-to-back words at every phase setting. A behavioural slave that answers with a fixed byte, together with a monitor on mosi, lets the bench tell a correct exchange from a reversed bit order and from a missed or extra edge.

// File: rtl/spim_pkg.sv
// Shared constants and helpers for the SPI master shift engine.
// Assumes a 17-bit control word whose field positions are fixed below.
package spim_pkg;
    localparam int SS_W     = 4;
    localparam int DIV_W    = 3;
    localparam int CTRL_W   = 17;

    // Control word bit positions, decoded by the engine
    localparam int B_MEN    = 0;
    localparam int B_CPOL   = 1;
    localparam int B_CPHA   = 2;
    localparam int B_DIV_LO = 3;
    localparam int B_DEC    = 9;
    localparam int B_SEL_LO = 10;
    localparam int B_MSEL   = 14;
    localparam int B_MGO_EN = 15;
    localparam int B_MGO    = 16;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
    } clk_cfg_t;

    // Keep only the lowest cleared bit of an active-low select field.
    function automatic logic [SS_W-1:0] lowest_clear(input logic [SS_W-1:0] f);
        logic [SS_W-1:0] r;
        r = '1;
        for (int i = SS_W - 1; i >= 0; i--) begin
            if (!f[i]) r = ~(SS_W'(1) << i);
        end
        return r;
    endfunction
endpackage

// File: rtl/spim_baud.sv
// Half-period tick generator for the serial clock.
// A tick fires every 2^N cycles while run is high; N = div code, 0 treated as 1.
// Assumes div is held constant while run is high.
module spim_baud #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] n_eff;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_q;

    // Clamp the code to the divide-by-4 minimum and derive the terminal count.
    always_comb begin
        n_eff = (div == '0) ? DIV_W'(1) : div;
        lim   = CNT_W'((32'd1 << n_eff) - 32'd1);
    end

    assign tick = run && (cnt_q == lim);

    // Count cycles within a half period; hold at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim))
        else $error("R3: half-period counter past its limit");
endmodule

// File: rtl/spim_shift.sv
// Word shifter: counts 2*WORD_W serial clock edges per word, drives mosi MSB
// first, samples miso on the phase-selected edge and delivers the word.
// Assumes load and abort are never high together.
module spim_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              abort,
    input  logic              tick,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              mosi,
    output logic              sclk,
    output logic              last,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0]     edge_q;
    logic              tog_q;
    logic [WORD_W-1:0] tx_sh_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic              smp;
    logic              shf;

    assign smp  = tick && (edge_q[0] == cpha);
    assign shf  = tick && (edge_q[0] != cpha) && !(cpha && edge_q == '0);
    assign last = tick && (edge_q == EW'(EDGES - 1));
    assign mosi = tx_sh_q[WORD_W-1];
    assign sclk = cpol ^ tog_q;

    // Edge counter, clock toggle and transmit shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q  <= '0;
            tog_q   <= 1'b0;
            tx_sh_q <= '0;
        end else if (load) begin
            edge_q  <= '0;
            tog_q   <= 1'b0;
            tx_sh_q <= tx_word;
        end else if (abort) begin
            edge_q  <= '0;
            tog_q   <= 1'b0;
        end else if (tick) begin
            edge_q <= last ? '0 : edge_q + 1'b1;
            tog_q  <= ~tog_q;
            if (shf) tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
        end
    end

    // Receive shift register, sampled on the phase-selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   rx_sh_q <= '0;
        else if (smp) rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso};
    end

    // Deliver the finished word one cycle after the final edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last && !abort;
            if (last) rx_word <= smp ? {rx_sh_q[WORD_W-2:0], miso} : rx_sh_q;
        end
    end

    a_r2_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (sclk == cpol))
        else $error("R2: sclk not idle after final edge");
endmodule

// File: rtl/spim_ssel.sv
// Registered slave-select driver: one-hot with lowest-index priority, or the
// raw field for an external decoder; manual or transfer-framed assertion.
module spim_ssel #(
    parameter int SS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SS_W-1:0] field,
    input  logic            decoded,
    input  logic            manual,
    input  logic            active,
    input  logic            busy,
    output logic [SS_W-1:0] ss_n
);
    import spim_pkg::*;

    // Select the drive pattern for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ss_n <= '1;
        else if (!active)                ss_n <= '1;
        else if (!(manual || busy))      ss_n <= '1;
        else if (decoded)                ss_n <= field;
        else                             ss_n <= lowest_clear(field);
    end

    a_r5_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!decoded) |-> ($countones(~ss_n) <= 1))
        else $error("R5: more than one select low in one-hot mode");

    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!active) |-> (ss_n == '1))
        else $error("R7: select asserted while engine inactive");
endmodule

// File: rtl/spi_shift_master.sv
// SPI master shift engine top: enable gating, clock-setting capture, start
// logic (automatic or triggered drain), mode-fault handling.
// Assumes a first-word-fall-through transmit queue (tx_byte valid when
// tx_empty is low) and a synchronous fault_n.
module spi_shift_master #(
    parameter int WORD_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [spim_pkg::CTRL_W-1:0] ctrl_word,
    input  logic                        eng_en,
    input  logic                        tx_empty,
    input  logic [WORD_W-1:0]           tx_byte,
    output logic                        tx_pop,
    output logic [WORD_W-1:0]           rx_byte,
    output logic                        rx_push,
    input  logic                        fault_n,
    output logic                        fault_evt,
    output logic                        sclk,
    output logic                        mosi,
    input  logic                        miso,
    output logic [spim_pkg::SS_W-1:0]   ss_n
);
    import spim_pkg::*;

    logic     en_q, run_q, busy_q, drain_q, trig_q;
    clk_cfg_t cfg_q;
    logic     en_rise, active, fault_hit, manual_go, trig, go, start, abort;
    logic     tick, last;
    logic     unused_bits;

    assign unused_bits = ^ctrl_word[8:6];
    assign en_rise   = eng_en && !en_q;
    assign active    = run_q && ctrl_word[B_MEN];
    assign fault_hit = active && !fault_n;
    assign manual_go = ctrl_word[B_MGO_EN];
    assign trig      = ctrl_word[B_MGO] && !trig_q;
    assign go        = active && (manual_go ? drain_q : 1'b1);
    assign start     = go && !tx_empty && (!busy_q || last) && !fault_hit;
    assign abort     = busy_q && (fault_hit || !active);
    assign tx_pop    = start;

    // Edge detectors for the enable input and the start trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            en_q   <= eng_en;
            trig_q <= ctrl_word[B_MGO];
        end
    end

    // Capture clock settings only when the enable rises.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '{cpol: 1'b0, cpha: 1'b0, div: DIV_W'(1)};
        else if (en_rise) cfg_q <= '{cpol: ctrl_word[B_CPOL], cpha: ctrl_word[B_CPHA],
                                     div:  ctrl_word[B_DIV_LO +: DIV_W]};
    end

    // Internal run flag: set by the enable edge, cleared by disable or fault.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (fault_hit)  run_q <= 1'b0;
        else if (!eng_en)    run_q <= 1'b0;
        else if (en_rise)    run_q <= 1'b1;
    end

    // Transfer-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (abort)  busy_q <= 1'b0;
        else if (start)  busy_q <= 1'b1;
        else if (last)   busy_q <= 1'b0;
    end

    // Triggered drain: armed by a trigger edge, dropped once the queue is dry.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)                    drain_q <= 1'b0;
        else if (manual_go && trig)               drain_q <= 1'b1;
        else if (tx_empty && (!busy_q || last))   drain_q <= 1'b0;
    end

    // One-cycle mode-fault event.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_evt <= 1'b0;
        else        fault_evt <= fault_hit;
    end

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .div   (cfg_q.div),
        .tick  (tick)
    );

    spim_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .abort    (abort),
        .tick     (tick),
        .tx_word  (tx_byte),
        .cpol     (cfg_q.cpol),
        .cpha     (cfg_q.cpha),
        .miso     (miso),
        .mosi     (mosi),
        .sclk     (sclk),
        .last     (last),
        .rx_word  (rx_byte),
        .rx_valid (rx_push)
    );

    spim_ssel #(.SS_W(SS_W)) u_ssel (
        .clk     (clk),
        .rst_n   (rst_n),
        .field   (ctrl_word[B_SEL_LO +: SS_W]),
        .decoded (ctrl_word[B_DEC]),
        .manual  (ctrl_word[B_MSEL]),
        .active  (active),
        .busy    (busy_q),
        .ss_n    (ss_n)
    );

    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rise |=> $stable(cfg_q))
        else $error("R4: clock settings changed without an enable edge");

    a_r9_wait_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (manual_go && !drain_q && !busy_q) |-> !tx_pop)
        else $error("R9: word started without a trigger");

    a_r10_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!tx_empty && active))
        else $error("R10: pop from empty queue or inactive engine");

    a_r11_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> !fault_evt)
        else $error("R11: fault event longer than one cycle");

    a_r11_evt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |-> !busy_q)
        else $error("R11: transfer still running after fault");
endmodule

// File: tb/tb_spi_shift_master.sv
// Directed bench for spi_shift_master: one task per scenario, each checking
// its own results against a behavioural slave and queue models.
module tb_spi_shift_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] ctrl = '0;
    logic        eng_en = 1'b0;
    logic        tx_empty, tx_pop, rx_push, sclk, mosi, fault_evt;
    logic        miso = 1'b0;
    logic        fault_n = 1'b1;
    logic [7:0]  tx_data, rx_data;
    logic [3:0]  ss_n;

    always #10 clk = ~clk;

    spi_shift_master #(.WORD_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .eng_en(eng_en),
        .tx_empty(tx_empty), .tx_byte(tx_data), .tx_pop(tx_pop),
        .rx_byte(rx_data), .rx_push(rx_push), .fault_n(fault_n),
        .fault_evt(fault_evt), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // Transmit queue model (first word falls through).
    logic [7:0] txq [0:15];
    int wr_i = 0, rd_i = 0;
    bit pend = 0;
    assign tx_empty = (rd_i == wr_i);
    assign tx_data  = txq[rd_i % 16];

    // Receive capture and slave/monitor state.
    logic [7:0] rxq [0:15];
    logic [7:0] monq [0:15];
    logic [7:0] mon_sh, slv;
    int rx_n = 0, mon_n = 0, mon_bits = 0, lead_n = 0, trail_n = 0;
    int lead_cyc [0:1];
    logic mosi_neg = 1'b0;
    bit cpol_t = 0, cpha_t = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        mosi_neg = mosi;
        if (pend) rd_i = rd_i + 1;
        pend = tx_pop;
        if (rx_push) begin
            rxq[rx_n % 16] = rx_data;
            rx_n = rx_n + 1;
        end
    end

    // Slave and mosi monitor, acting on sclk edges.
    always @(posedge sclk or negedge sclk) begin
        if (sclk != cpol_t) begin
            if (lead_n < 2) lead_cyc[lead_n] = cyc;
            if (!cpha_t) capture();
            else miso = slv[7 - (lead_n % 8)];
            lead_n = lead_n + 1;
        end else begin
            trail_n = trail_n + 1;
            if (cpha_t) capture();
            else miso = slv[7 - (trail_n % 8)];
        end
    end

    task automatic capture();
        mon_sh = {mon_sh[6:0], mosi_neg};
        mon_bits = mon_bits + 1;
        if (mon_bits == 8) begin
            monq[mon_n % 16] = mon_sh;
            mon_n = mon_n + 1;
            mon_bits = 0;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(bit men, bit cp, bit ph, logic [2:0] dv, bit dec,
                                       logic [3:0] sel, bit msel, bit mgo_en, bit mgo);
        logic [16:0] c;
        c = '0;
        c[0] = men; c[1] = cp; c[2] = ph; c[5:3] = dv; c[9] = dec;
        c[13:10] = sel; c[14] = msel; c[15] = mgo_en; c[16] = mgo;
        return c;
    endfunction

    task automatic cw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        txq[wr_i % 16] = b;
        wr_i = wr_i + 1;
    endtask

    task automatic wait_rx(input int target);
        for (int i = 0; i < 20000 && rx_n < target; i++) @(negedge clk);
    endtask

    task automatic reset_mon(input logic [7:0] s);
        slv = s; lead_n = 0; trail_n = 0; mon_bits = 0; mon_n = 0;
        miso = s[7];
    endtask

    task automatic prep(input bit cp, input bit ph, input logic [2:0] dv, input logic [16:0] c,
                        input logic [7:0] s);
        eng_en = 1'b0;
        cpol_t = cp; cpha_t = ph;
        ctrl = c;
        cw(2);
        eng_en = 1'b1;
        cw(3);
        reset_mon(s);
    endtask

    // R1: state straight out of reset.
    task automatic t_reset();
        chk(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(!tx_pop && !rx_push && !fault_evt, "R1 strobes",
            {tx_pop, rx_push, fault_evt}, 0);
    endtask

    // R10: no start without an enable edge and master enable.
    task automatic t_gate();
        int rb;
        rb = rx_n;
        reset_mon(8'h3C);
        ctrl = mk(0, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0);
        push(8'h5A);
        cw(40);
        chk(rd_i == 0, "R10 no pop while disabled", rd_i, 0);
        eng_en = 1'b1;
        cw(40);
        chk(rd_i == 0, "R10 no pop without master enable", rd_i, 0);
        chk(ss_n == 4'hF, "R10 select idle", ss_n, 4'hF);
        ctrl[0] = 1'b1;
        wait_rx(rb + 1);
        cw(4);
        chk(rx_n == rb + 1 && rxq[rb % 16] == 8'h3C, "R10 runs once enabled",
            rxq[rb % 16], 8'h3C);
    endtask

    // R2, R3: exchange in one clock mode with a given divider code.
    task automatic t_xfer(input bit cp, input bit ph, input logic [2:0] dv,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] s);
        int rb, pb, per, ne;
        prep(cp, ph, dv, mk(1, cp, ph, dv, 0, 4'b1110, 0, 0, 0), s);
        rb = rx_n; pb = rd_i;
        push(b0); push(b1);
        wait_rx(rb + 2);
        cw(4);
        chk(rx_n - rb == 2 && rd_i - pb == 2, "R2 one push per pop", rx_n - rb, 2);
        chk(rxq[rb % 16] == s, "R2 rx word 0", rxq[rb % 16], s);
        chk(rxq[(rb + 1) % 16] == s, "R2 rx word 1", rxq[(rb + 1) % 16], s);
        chk(monq[0] == b0, "R2 mosi MSB first word 0", monq[0], b0);
        chk(monq[1] == b1, "R2 mosi MSB first word 1", monq[1], b1);
        ne = (dv == 0) ? 1 : int'(dv);
        per = lead_cyc[1] - lead_cyc[0];
        chk(per == (1 << (ne + 1)), "R3 sclk period", per, 1 << (ne + 1));
        chk(sclk == cp, "R2 sclk idle level", sclk, cp);
    endtask

    // R4: clock settings written while enabled do not apply.
    task automatic t_cfg_hold();
        int rb, per;
        prep(0, 0, 3'd1, mk(1, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0), 8'h96);
        ctrl = mk(1, 1, 0, 3'd3, 0, 4'b1110, 0, 0, 0);
        cw(5);
        chk(sclk == 1'b0, "R4 idle level held", sclk, 0);
        rb = rx_n;
        push(8'h21);
        wait_rx(rb + 1);
        per = lead_cyc[1] - lead_cyc[0];
        chk(per == 4, "R4 period held", per, 4);
        eng_en = 1'b0;
        cw(2);
        eng_en = 1'b1;
        cw(3);
        chk(sclk == 1'b1, "R4 new idle level after enable edge", sclk, 1);
    endtask

    // R5, R6, R7: select drive during and after a transfer.
    task automatic t_select(input bit dec, input logic [3:0] sel, input logic [3:0] exp,
                            input string tag);
        int rb;
        prep(0, 0, 3'd1, mk(1, 0, 0, 3'd1, dec, sel, 0, 0, 0), 8'h0F);
        chk(ss_n == 4'hF, "R7 deselected before data", ss_n, 4'hF);
        rb = rx_n;
        push(8'hC3); push(8'h18);
        for (int i = 0; i < 200 && lead_n < 12; i++) @(negedge clk);
        chk(ss_n == exp, tag, ss_n, exp);
        wait_rx(rb + 2);
        cw(4);
        chk(ss_n == 4'hF, "R7 deselected after drain", ss_n, 4'hF);
    endtask

    // R8: manual select drives the field while enabled.
    task automatic t_manual_sel();
        prep(0, 0, 3'd1, mk(1, 0, 0, 3'd1, 0, 4'b0111, 1, 0, 0), 8'h00);
        cw(3);
        chk(ss_n == 4'b0111, "R8 manual select driven", ss_n, 4'b0111);
        eng_en = 1'b0;
        cw(3);
        chk(ss_n == 4'hF, "R8 released when disabled", ss_n, 4'hF);
    endtask

    // R9: triggered drain.
    task automatic t_manual_start();
        int rb, pb;
        logic [16:0] c;
        c = mk(1, 0, 1, 3'd2, 0, 4'b1110, 0, 1, 0);
        prep(0, 1, 3'd2, c, 8'h6D);
        rb = rx_n; pb = rd_i;
        push(8'h11); push(8'h22); push(8'h33);
        cw(100);
        chk(rd_i == pb, "R9 no start before trigger", rd_i - pb, 0);
        ctrl = c | 17'h10000;
        @(negedge clk);
        ctrl = c;
        wait_rx(rb + 3);
        cw(4);
        chk(rd_i - pb == 3 && rx_n - rb == 3, "R9 trigger drains queue", rd_i - pb, 3);
        chk(monq[2] == 8'h33 && rxq[(rb + 2) % 16] == 8'h6D, "R9 drained data",
            monq[2], 8'h33);
        push(8'h44);
        cw(100);
        chk(rd_i - pb == 3, "R9 waits for next trigger", rd_i - pb, 3);
        ctrl = c | 17'h10000;
        @(negedge clk);
        ctrl = c;
        wait_rx(rb + 4);
        cw(4);
        chk(rx_n - rb == 4, "R9 second trigger", rx_n - rb, 4);
    endtask

    // R11: mode fault mid-word.
    task automatic t_fault();
        int rb, pb;
        prep(0, 0, 3'd3, mk(1, 0, 0, 3'd3, 0, 4'b1101, 0, 0, 0), 8'hB4);
        rb = rx_n; pb = rd_i;
        push(8'h77); push(8'h88);
        for (int i = 0; i < 500 && lead_n < 3; i++) @(negedge clk);
        fault_n = 1'b0;
        @(negedge clk);
        chk(fault_evt == 1'b1, "R11 fault event raised", fault_evt, 1);
        @(negedge clk);
        chk(fault_evt == 1'b0, "R11 fault event one cycle", fault_evt, 0);
        @(negedge clk);
        fault_n = 1'b1;
        cw(300);
        chk(rx_n == rb, "R11 aborted word not pushed", rx_n - rb, 0);
        chk(rd_i - pb == 1, "R11 engine stopped", rd_i - pb, 1);
        chk(sclk == 1'b0 && ss_n == 4'hF, "R11 lines idle", {sclk, ss_n}, 5'h0F);
        eng_en = 1'b0;
        cw(2);
        reset_mon(8'hB4);
        eng_en = 1'b1;
        wait_rx(rb + 1);
        cw(4);
        chk(rx_n - rb == 1 && rxq[rb % 16] == 8'hB4, "R11 resumes after enable edge",
            rxq[rb % 16], 8'hB4);
    endtask

    initial begin
        cw(4);
        rst_n = 1'b1;
        cw(2);
        t_reset();
        t_gate();
        t_xfer(0, 0, 3'd1, 8'hA1, 8'h3E, 8'h5C);
        t_xfer(0, 1, 3'd2, 8'h81, 8'h7E, 8'hC6);
        t_xfer(1, 0, 3'd3, 8'h0D, 8'hF2, 8'h39);
        t_xfer(1, 1, 3'd0, 8'hE4, 8'h1B, 8'h8A);
        t_xfer(0, 1, 3'd7, 8'h9C, 8'h63, 8'h47);
        t_cfg_hold();
        t_select(0, 4'b1011, 4'b1011, "R5 one-hot select slave 2");
        t_select(0, 4'b0101, 4'b1101, "R5 lowest cleared bit wins");
        t_select(1, 4'b0010, 4'b0010, "R6 decoded field driven raw");
        t_manual_sel();
        t_manual_start();
        t_fault();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule